// File: doc/BRIEF.md
# S/PDIF Subframe Validity Controller

This block decides, for every left or right subframe of an S/PDIF stream, which audio sample word goes into the subframe and what the validity flag is. Each channel has a 20-bit sample input with a strobe and a "good" qualifier from the controller side. A channel holds its latest sample until that channel's subframe is assembled, and then discards it. A subframe that finds no held sample, or only a sample marked bad, gets an all-zero word and is flagged invalid.

Two configuration bits, loaded together by a write strobe, set the validity policy. The force bit on its own marks every subframe invalid, and the sample words pass through unchanged. The alternate bit on its own has no effect. Both bits together form a reserved code, and it behaves exactly like normal tracking. Downstream framing logic starts a subframe with a one-cycle start pulse and a channel select. One cycle later it gets the word, the flag and a 32-bit slot image with the fields already in their subframe bit positions. Preamble, parity, channel-status, user bits and biphase coding are produced elsewhere.

Top module: `spdif_validity_ctrl`

## Requirements
- R1: After reset both configuration bits are 0, no sample is held on either channel, and `sf_vld` is 0. The first subframe started after reset therefore has word 0 and validity 1.
- R2: A subframe start sampled on a clock edge gives `sf_vld`=1 on the next cycle. If the selected channel holds a sample strobed with good=1, `sf_word` equals that sample and `sf_vbit` is 0, unless forcing is active.
- R3: If the selected channel holds no sample, `sf_word` is 0 and `sf_vbit` is 1.
- R4: A sample strobed with good=0 produces word 0 and `sf_vbit`=1 in its subframe.
- R5: With force=1 and alt=0 loaded, every subframe on both channels has `sf_vbit`=1. The word still follows R2, R3 and R4.
- R6: The reserved code (force=1, alt=1) and the code (force=0, alt=1) both give the same validity and word as force=0, alt=0.
- R7: The channels are independent. `sf_sel`=0 selects left and 1 selects right, and `sf_ch` echoes the selection. A missing sample on one channel does not affect the other channel's subframe.
- R8: A channel's held sample is consumed by its subframe start. A later subframe on that channel with no new strobe follows R3.
- R9: If a strobe and a start for the same channel fall on the same edge, the subframe uses the sample held before that edge, and the new sample is kept for the next subframe.
- R10: `sf_slot` holds the validity flag at bit 28 and the sample word at bits 27:8, and all its other bits are 0. When `sf_vld` is 0, `sf_word`, `sf_vbit`, `sf_ch` and `sf_slot` are all 0.
- R11: A configuration write affects starts sampled from the next edge on. Changing `cfg_force` or `cfg_alt` without `cfg_wr` has no effect.
- R12: A second strobe on a channel before that channel's subframe replaces the held sample and its good qualifier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Loads `cfg_force` and `cfg_alt` |
| cfg_force | input | 1 | Force-invalid policy bit |
| cfg_alt | input | 1 | Alternate policy bit (see R6) |
| l_sample | input | 20 | Left sample word |
| l_stb | input | 1 | Left sample arrival strobe |
| l_good | input | 1 | Left sample is valid |
| r_sample | input | 20 | Right sample word |
| r_stb | input | 1 | Right sample arrival strobe |
| r_good | input | 1 | Right sample is valid |
| sf_start | input | 1 | Subframe start pulse |
| sf_sel | input | 1 | Channel of the started subframe (0 left, 1 right) |
| sf_vld | output | 1 | Subframe fields present |
| sf_ch | output | 1 | Channel of the presented subframe |
| sf_word | output | 20 | Sample word, zero-padded when missing or bad |
| sf_vbit | output | 1 | Validity flag (1 = invalid) |
| sf_slot | output | 32 | Word and flag at their subframe bit positions |

## Verification
The hardest case to reach from the ports is a strobe and a start for the same channel on one edge while an older sample is still held. The start must take the old sample and the new one must survive the consumption. The stimulus first loads a channel, then raises the strobe and the start in the same cycle, and then starts that channel again with no strobe. Mid-stream policy writes, and writes landing on the same edge as a start, are mixed into a long pseudo-random run.

// File: rtl/spdif_vc_pkg.sv
package spdif_vc_pkg;

  localparam int unsigned NUM_CH   = 2;
  localparam int unsigned SEL_W    = 1;
  localparam int unsigned SLOT_W   = 32;
  localparam int unsigned VBIT_POS = 28;

  // encoded as {alt, force}
  typedef enum logic [1:0] {
    MODE_TRACK = 2'b00,
    MODE_FORCE = 2'b01,
    MODE_ALT   = 2'b10,
    MODE_RSVD  = 2'b11
  } vmode_e;

  function automatic logic mode_forces(vmode_e m);
    return (m == MODE_FORCE);
  endfunction

endpackage

// File: rtl/spdif_vc_cfg.sv
module spdif_vc_cfg
  import spdif_vc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic force_in,
  input  logic alt_in,
  output logic force_all
);

  vmode_e mode_q;
  vmode_e mode_d;

  always_comb begin
    mode_d = mode_q;
    if (wr) begin
      mode_d = vmode_e'({alt_in, force_in});
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_TRACK;
    end else if (wr) begin
      mode_q <= mode_d;
    end
  end

  assign force_all = mode_forces(mode_q);

endmodule

// File: rtl/spdif_vc_chan.sv
module spdif_vc_chan #(
  parameter int unsigned SAMPLE_W = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                stb,
  input  logic                good,
  input  logic [SAMPLE_W-1:0] data,
  input  logic                consume,
  output logic                held,
  output logic                ok,
  output logic [SAMPLE_W-1:0] word
);

  logic                held_q, held_d;
  logic                good_q, good_d;
  logic [SAMPLE_W-1:0] data_q, data_d;
  logic                load;

  assign load = stb | consume;

  always_comb begin
    held_d = held_q;
    good_d = good_q;
    data_d = data_q;
    if (consume) begin
      held_d = 1'b0;
      good_d = 1'b0;
      data_d = '0;
    end
    // arrival on the consuming edge is kept for the next subframe
    if (stb) begin
      held_d = 1'b1;
      good_d = good;
      data_d = good ? data : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      good_q <= 1'b0;
      data_q <= '0;
    end else if (load) begin
      held_q <= held_d;
      good_q <= good_d;
      data_q <= data_d;
    end
  end

  assign held = held_q;
  assign ok   = held_q & good_q;
  assign word = data_q;

endmodule

// File: rtl/spdif_vc_emit.sv
module spdif_vc_emit
  import spdif_vc_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 20
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              start,
  input  logic [SEL_W-1:0]                  sel,
  input  logic [NUM_CH-1:0]                 ok_vec,
  input  logic [NUM_CH-1:0][SAMPLE_W-1:0]   word_vec,
  input  logic                              force_all,
  output logic                              vld,
  output logic [SEL_W-1:0]                  ch,
  output logic [SAMPLE_W-1:0]               word,
  output logic                              vbit
);

  logic                vld_q, vld_d;
  logic [SEL_W-1:0]    ch_q, ch_d;
  logic [SAMPLE_W-1:0] word_q, word_d;
  logic                vbit_q, vbit_d;
  logic                pick_ok;
  logic                load;

  assign pick_ok = ok_vec[sel];
  assign load    = start | vld_q;

  always_comb begin
    vld_d  = 1'b0;
    ch_d   = '0;
    word_d = '0;
    vbit_d = 1'b0;
    if (start) begin
      vld_d  = 1'b1;
      ch_d   = sel;
      word_d = pick_ok ? word_vec[sel] : '0;
      vbit_d = force_all | ~pick_ok;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      ch_q   <= '0;
      word_q <= '0;
      vbit_q <= 1'b0;
    end else if (load) begin
      vld_q  <= vld_d;
      ch_q   <= ch_d;
      word_q <= word_d;
      vbit_q <= vbit_d;
    end
  end

  assign vld  = vld_q;
  assign ch   = ch_q;
  assign word = word_q;
  assign vbit = vbit_q;

endmodule

// File: rtl/spdif_validity_ctrl.sv
module spdif_validity_ctrl
  import spdif_vc_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_wr,
  input  logic                cfg_force,
  input  logic                cfg_alt,
  input  logic [SAMPLE_W-1:0] l_sample,
  input  logic                l_stb,
  input  logic                l_good,
  input  logic [SAMPLE_W-1:0] r_sample,
  input  logic                r_stb,
  input  logic                r_good,
  input  logic                sf_start,
  input  logic                sf_sel,
  output logic                sf_vld,
  output logic                sf_ch,
  output logic [SAMPLE_W-1:0] sf_word,
  output logic                sf_vbit,
  output logic [31:0]         sf_slot
);

  localparam int unsigned LSB_PAD = VBIT_POS - SAMPLE_W;

  logic                            force_all;
  logic [NUM_CH-1:0]               stb_vec;
  logic [NUM_CH-1:0]               good_vec;
  logic [NUM_CH-1:0][SAMPLE_W-1:0] in_vec;
  logic [NUM_CH-1:0]               consume_vec;
  logic [NUM_CH-1:0]               chan_held;
  logic [NUM_CH-1:0]               chan_ok;
  logic [NUM_CH-1:0][SAMPLE_W-1:0] held_word;

  assign stb_vec  = {r_stb, l_stb};
  assign good_vec = {r_good, l_good};
  assign in_vec   = {r_sample, l_sample};

  spdif_vc_cfg u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (cfg_wr),
    .force_in  (cfg_force),
    .alt_in    (cfg_alt),
    .force_all (force_all)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    assign consume_vec[c] = sf_start & (sf_sel == SEL_W'(c));

    spdif_vc_chan #(.SAMPLE_W(SAMPLE_W)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .stb     (stb_vec[c]),
      .good    (good_vec[c]),
      .data    (in_vec[c]),
      .consume (consume_vec[c]),
      .held    (chan_held[c]),
      .ok      (chan_ok[c]),
      .word    (held_word[c])
    );
  end

  spdif_vc_emit #(.SAMPLE_W(SAMPLE_W)) u_emit (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (sf_start),
    .sel       (sf_sel),
    .ok_vec    (chan_ok),
    .word_vec  (held_word),
    .force_all (force_all),
    .vld       (sf_vld),
    .ch        (sf_ch),
    .word      (sf_word),
    .vbit      (sf_vbit)
  );

  always_comb begin
    sf_slot = '0;
    sf_slot[VBIT_POS] = sf_vbit;
    sf_slot[LSB_PAD +: SAMPLE_W] = sf_word;
  end

endmodule

// File: rtl/spdif_validity_ctrl_chk.sv
module spdif_validity_ctrl_chk #(
  parameter int unsigned SAMPLE_W = 20
) (
  input logic                clk,
  input logic                rst_n,
  input logic                sf_start,
  input logic                sf_sel,
  input logic                sf_vld,
  input logic                sf_ch,
  input logic [SAMPLE_W-1:0] sf_word,
  input logic                sf_vbit,
  input logic [31:0]         sf_slot,
  input logic                force_all,
  input logic [1:0]          chan_ok,
  input logic [1:0]          chan_held,
  input logic [1:0]          stb_vec
);

  localparam int unsigned LSB_PAD = 28 - SAMPLE_W;
  localparam logic [31:0] FIELD_MASK = ((32'd1 << (SAMPLE_W + 1)) - 32'd1) << LSB_PAD;

  AST_START_TO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    sf_start |=> sf_vld); // R2

  AST_VALID_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (sf_start && chan_ok[sf_sel] && !force_all) |=> !sf_vbit); // R2

  AST_MISSING_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    (sf_start && !chan_ok[sf_sel]) |=> (sf_vbit && sf_word == '0)); // R3

  AST_FORCE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (sf_start && force_all) |=> sf_vbit); // R5

  AST_CHAN_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    sf_start |=> (sf_ch == $past(sf_sel))); // R7

  AST_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
    (sf_start && !stb_vec[sf_sel]) |=> !chan_held[$past(sf_sel)]); // R8

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !sf_start |=> (!sf_vld && sf_word == '0 && !sf_vbit && !sf_ch)); // R10

  AST_SLOT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (sf_slot & ~FIELD_MASK) == 32'd0); // R10

endmodule

bind spdif_validity_ctrl spdif_validity_ctrl_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sf_start  (sf_start),
  .sf_sel    (sf_sel),
  .sf_vld    (sf_vld),
  .sf_ch     (sf_ch),
  .sf_word   (sf_word),
  .sf_vbit   (sf_vbit),
  .sf_slot   (sf_slot),
  .force_all (force_all),
  .chan_ok   (chan_ok),
  .chan_held (chan_held),
  .stb_vec   (stb_vec)
);

// File: tb/spdif_validity_ctrl_test.sv
`timescale 1ns/1ps
module spdif_validity_ctrl_test;

  logic        clk;
  logic        rst_n;
  logic        cfg_wr, cfg_force, cfg_alt;
  logic [19:0] l_sample, r_sample;
  logic        l_stb, l_good, r_stb, r_good;
  logic        sf_start, sf_sel;
  logic        sf_vld, sf_ch, sf_vbit;
  logic [19:0] sf_word;
  logic [31:0] sf_slot;

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 0;
  string cur_req = "R1";

  // reference model state
  bit          m_held [2];
  bit          m_ok   [2];
  logic [19:0] m_data [2];
  bit          m_force;
  bit          e_vld, e_ch, e_vbit;
  logic [19:0] e_word;

  spdif_validity_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr(cfg_wr), .cfg_force(cfg_force), .cfg_alt(cfg_alt),
    .l_sample(l_sample), .l_stb(l_stb), .l_good(l_good),
    .r_sample(r_sample), .r_stb(r_stb), .r_good(r_good),
    .sf_start(sf_start), .sf_sel(sf_sel),
    .sf_vld(sf_vld), .sf_ch(sf_ch), .sf_word(sf_word),
    .sf_vbit(sf_vbit), .sf_slot(sf_slot)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  task automatic chk(input bit cond, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // behavioural model, updated on each rising edge
  always @(posedge clk or negedge rst_n) begin
    bit okp;
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        m_held[i] = 0; m_ok[i] = 0; m_data[i] = '0;
      end
      m_force = 0;
      e_vld = 0; e_ch = 0; e_vbit = 0; e_word = '0;
    end else begin
      e_vld = sf_start;
      if (sf_start) begin
        okp    = m_held[sf_sel] && m_ok[sf_sel];
        e_ch   = sf_sel;
        e_word = okp ? m_data[sf_sel] : 20'h0;
        e_vbit = m_force || !okp;
        m_held[sf_sel] = 0;
      end else begin
        e_ch = 0; e_word = '0; e_vbit = 0;
      end
      if (l_stb) begin m_held[0] = 1; m_ok[0] = l_good; m_data[0] = l_sample; end
      if (r_stb) begin m_held[1] = 1; m_ok[1] = r_good; m_data[1] = r_sample; end
      if (cfg_wr) m_force = cfg_force && !cfg_alt;
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(sf_vld == e_vld, cur_req, "sf_vld", 32'(sf_vld), 32'(e_vld));
      chk(sf_ch == e_ch, "R7", "sf_ch", 32'(sf_ch), 32'(e_ch));
      chk(sf_word == e_word, cur_req, "sf_word", 32'(sf_word), 32'(e_word));
      chk(sf_vbit == e_vbit, cur_req, "sf_vbit", 32'(sf_vbit), 32'(e_vbit));
      chk(sf_slot == {3'b000, e_vbit, e_word, 8'h00}, "R10", "sf_slot",
          sf_slot, {3'b000, e_vbit, e_word, 8'h00});
    end
  end

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    #1;
    l_stb = 0; r_stb = 0; sf_start = 0; cfg_wr = 0;
  endtask

  task automatic push(input bit ch, input bit good, input logic [19:0] d);
    if (ch) begin r_stb = 1; r_good = good; r_sample = d; end
    else    begin l_stb = 1; l_good = good; l_sample = d; end
  endtask

  task automatic start(input bit ch);
    sf_start = 1; sf_sel = ch;
  endtask

  task automatic wcfg(input bit f, input bit a);
    cfg_wr = 1; cfg_force = f; cfg_alt = a;
  endtask

  // watchdog
  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    cfg_wr = 0; cfg_force = 0; cfg_alt = 0;
    l_sample = '0; r_sample = '0; l_stb = 0; r_stb = 0; l_good = 0; r_good = 0;
    sf_start = 0; sf_sel = 0;
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    @(negedge clk); #1;
    // R1: reset state and first empty subframe
    cur_req = "R1";
    chk(sf_vld == 0, "R1", "sf_vld after reset", 32'(sf_vld), 0);
    chk(sf_slot == 0, "R1", "sf_slot after reset", sf_slot, 0);
    start(0); tick();
    chk(sf_vbit == 1 && sf_word == 0, "R1", "first subframe", 32'(sf_vbit), 1);

    cur_req = "R2";
    push(0, 1, 20'hABCDE); tick(); start(0); tick();
    chk(sf_vbit == 0 && sf_word == 20'hABCDE, "R2", "left valid word", 32'(sf_word), 32'h000ABCDE);
    push(1, 1, 20'h13579); tick(); start(1); tick(); tick();

    cur_req = "R3";
    start(1); tick(); tick();

    cur_req = "R4";
    push(0, 0, 20'h12345); tick(); start(0); tick();
    chk(sf_word == 0 && sf_vbit == 1, "R4", "bad sample padded", 32'(sf_word), 0);

    cur_req = "R5";
    wcfg(1, 0); tick();
    push(0, 1, 20'h0F0F0); push(1, 1, 20'hF0F0F); tick();
    start(0); tick(); start(1); tick();
    chk(sf_vbit == 1 && sf_word == 20'hF0F0F, "R5", "forced invalid right", 32'(sf_vbit), 1);
    start(0); tick(); tick();

    cur_req = "R6";
    wcfg(1, 1); tick();
    push(0, 1, 20'h55555); tick(); start(0); tick();
    chk(sf_vbit == 0, "R6", "reserved acts as tracking", 32'(sf_vbit), 0);
    wcfg(0, 1); tick();
    push(1, 1, 20'h2AAAA); tick(); start(1); tick();
    chk(sf_vbit == 0, "R6", "alt-only acts as tracking", 32'(sf_vbit), 0);
    wcfg(0, 0); tick();

    cur_req = "R7";
    push(0, 1, 20'h77777); tick(); start(0); tick(); start(1); tick();
    chk(sf_ch == 1 && sf_vbit == 1, "R7", "right missing", 32'(sf_vbit), 1);
    tick();

    cur_req = "R8";
    push(0, 1, 20'h88888); tick(); start(0); tick(); start(0); tick();
    chk(sf_vbit == 1 && sf_word == 0, "R8", "sample consumed", 32'(sf_word), 0);
    tick();

    cur_req = "R9";
    push(1, 1, 20'h99991); tick();
    push(1, 1, 20'h99992); start(1); tick();
    chk(sf_word == 20'h99991, "R9", "old sample used", 32'(sf_word), 32'h00099991);
    start(1); tick();
    chk(sf_word == 20'h99992 && sf_vbit == 0, "R9", "new sample kept", 32'(sf_word), 32'h00099992);
    tick();

    cur_req = "R11";
    cfg_force = 1; cfg_alt = 0; tick();
    push(0, 1, 20'h11111); tick(); start(0); tick();
    chk(sf_vbit == 0, "R11", "no write no effect", 32'(sf_vbit), 0);
    push(0, 1, 20'h11112); wcfg(1, 0); start(1); tick();
    start(0); tick();
    chk(sf_vbit == 1, "R11", "write effective next edge", 32'(sf_vbit), 1);
    wcfg(0, 0); tick();

    cur_req = "R12";
    push(0, 0, 20'hCCCCC); tick(); push(0, 1, 20'hDDDDD); tick(); start(0); tick();
    chk(sf_word == 20'hDDDDD && sf_vbit == 0, "R12", "latest sample wins", 32'(sf_word), 32'h000DDDDD);
    tick();

    cur_req = "R2";
    for (int n = 0; n < 2000; n++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 40) push(0, $urandom_range(0, 3) != 0, 20'($urandom));
      r = $urandom_range(0, 99);
      if (r < 40) push(1, $urandom_range(0, 3) != 0, 20'($urandom));
      if ($urandom_range(0, 99) < 50) start($urandom_range(0, 1));
      if ($urandom_range(0, 99) < 5) wcfg($urandom_range(0, 1), $urandom_range(0, 1));
      tick();
    end
    tick();

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule